// File: doc/BRIEF.md
# Master Clock Rate Selector and Startup Sequencer

This block runs on the external master clock of an audio converter datapath and turns it into a clock enable at 256 times the sample rate. When the master clock runs at 256fs, the enable is high on every cycle. When it runs at 384fs, the enable fires on two of every three cycles. The divider is only a clock-enable pattern. No derived clock is ever produced.

The block also decides when the datapath may leave power-down. After reset it keeps the ready output low until the frame (left/right) clock has shown two synchronized edges, each within a timeout counted in master clock cycles. Operation begins on the second of those edges. If the frame clock later stops for a whole timeout window, the block falls back to power-down. The rate-select pin is captured only while powered down. A one-cycle frame-start strobe marks each rising edge of the frame clock while running.

Top module: `clk_mode_seq`

## Requirements
- R1: While `rst_n` is low, `ready`, `tick_256` and `frame_start` are all 0.
- R2: `ready` stays 0 after reset until two frame-clock edges (either direction) have been seen, the second within TIMEOUT master cycles of the first. `frame_clk` passes through a 2-stage synchronizer. The block reads a level change on `frame_clk` at clock edge k and enters the ready state on edge k+2 after the second such change. `ready` is therefore 1 when sampled after edge k+2 and 0 after edge k+1.
- R3: While ready with the captured select at 0 (256fs mode), `tick_256` is 1 on every master cycle.
- R4: While ready with the captured select at 1 (384fs mode), `tick_256` repeats the pattern 1,1,0, starting with 1 on the first ready cycle.
- R5: `sel_384` is captured on every cycle in which `ready` is 0. While `ready` is 1, changes on it have no effect on `tick_256`.
- R6: After the first edge, or while ready, if TIMEOUT consecutive master cycles pass with no synchronized frame edge, the block returns to power-down (`ready` 0). A new two-edge qualification is then required.
- R7: `frame_start` is high for exactly one master cycle for each synchronized rising edge of `frame_clk` seen while ready, on the same cycle that edge becomes visible. It is never high on falling edges or in power-down.
- R8: `tick_256` is 0 whenever `ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | External master clock (256fs or 384fs) |
| rst_n | input | 1 | Asynchronous active-low reset; low forces power-down |
| sel_384 | input | 1 | Rate select: 0 = master clock is 256fs, 1 = 384fs |
| frame_clk | input | 1 | Left/right frame clock at fs, synchronous in frequency but arbitrary in phase |
| tick_256 | output | 1 | Internal 256fs clock enable |
| ready | output | 1 | 1 = operating, 0 = power-down |
| frame_start | output | 1 | One-cycle strobe on each frame-clock rising edge while ready |

## Verification
The hardest state to reach is the fall back from running to power-down and the later requalification. This path needs the frame clock to go silent for a full timeout window, to come back with only a single edge, and then to come back properly with a different select value. The stimulus gets there with directed phases that gate the frame-clock generator off for more than TIMEOUT cycles. It also sends an isolated single edge to exercise the armed-state timeout, and it flips the select pin both during the run and during power-down. Random segments vary the frame half-period and the select between these phases. A cycle model in the bench predicts every output on every cycle.

// File: rtl/cms_pkg.sv
package cms_pkg;
  typedef enum logic [1:0] {
    ST_PDN = 2'd0,
    ST_ARM = 2'd1,
    ST_RUN = 2'd2
  } seq_state_t;

  localparam int unsigned DIV_LEN = 3;

  // next slot of the 2/3 pattern; stays at 0 when full rate is selected
  function automatic logic [1:0] div_next(input logic [1:0] slot, input logic mode_384);
    if (!mode_384) return 2'd0;
    return (slot == 2'(DIV_LEN - 1)) ? 2'd0 : slot + 2'd1;
  endfunction

  // enable value for a given slot: drop the last slot of each group of three
  function automatic logic div_tick(input logic [1:0] slot, input logic mode_384);
    return !mode_384 || (slot != 2'(DIV_LEN - 1));
  endfunction
endpackage

// File: rtl/frame_sync.sv
module frame_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic edge_o,
  output logic rise_o
);
  localparam int unsigned W = STAGES + 1;
  logic [W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[W-2:0], async_i};
  end

  assign edge_o = pipe_q[W-2] ^ pipe_q[W-1];
  assign rise_o = pipe_q[W-2] & ~pipe_q[W-1];
endmodule

// File: rtl/presence_seq.sv
module presence_seq
  import cms_pkg::*;
#(
  parameter int unsigned TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  output logic run_o
);
  localparam int unsigned CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  seq_state_t st_q;
  logic [CW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_PDN;
      gap_q <= '0;
    end else begin
      case (st_q)
        ST_PDN: begin
          gap_q <= '0;
          if (edge_i) st_q <= ST_ARM;
        end
        ST_ARM, ST_RUN: begin
          if (edge_i) begin
            gap_q <= '0;
            st_q  <= ST_RUN;
          end else if (gap_q == LAST) begin
            gap_q <= '0;
            st_q  <= ST_PDN;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: st_q <= ST_PDN;
      endcase
    end
  end

  assign run_o = (st_q == ST_RUN);
endmodule

// File: rtl/rate_div.sv
module rate_div
  import cms_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic sel_i,
  output logic tick_o,
  output logic mode_o
);
  logic       mode_q;
  logic [1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      slot_q <= '0;
    end else begin
      if (!run_i) begin
        mode_q <= sel_i;
        slot_q <= '0;
      end else begin
        slot_q <= div_next(slot_q, mode_q);
      end
    end
  end

  assign tick_o = run_i & div_tick(slot_q, mode_q);
  assign mode_o = mode_q;
endmodule

// File: rtl/clk_mode_seq.sv
module clk_mode_seq #(
  parameter int unsigned TIMEOUT     = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic sel_384,
  input  logic frame_clk,
  output logic tick_256,
  output logic ready,
  output logic frame_start
);
  logic frame_edge;
  logic frame_rise;
  logic run;
  logic mode_cap;

  frame_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(mclk), .rst_n(rst_n), .async_i(frame_clk),
    .edge_o(frame_edge), .rise_o(frame_rise)
  );

  presence_seq #(.TIMEOUT(TIMEOUT)) u_seq (
    .clk(mclk), .rst_n(rst_n), .edge_i(frame_edge), .run_o(run)
  );

  rate_div u_div (
    .clk(mclk), .rst_n(rst_n), .run_i(run), .sel_i(sel_384),
    .tick_o(tick_256), .mode_o(mode_cap)
  );

  assign ready       = run;
  assign frame_start = run & frame_rise;
endmodule

// File: rtl/clk_mode_seq_checker.sv
module clk_mode_seq_checker (
  input logic mclk,
  input logic rst_n,
  input logic tick_256,
  input logic ready,
  input logic frame_start,
  input logic frame_edge,
  input logic mode_cap
);
  p_reset_quiet_r1: assert property (@(posedge mclk)
    !rst_n |-> (!ready && !tick_256 && !frame_start));

  p_ready_needs_edge_r2: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(ready) |-> $past(frame_edge));

  p_full_rate_r3: assert property (@(posedge mclk) disable iff (!rst_n)
    (ready && !mode_cap) |-> tick_256);

  p_third_gap_r4: assert property (@(posedge mclk) disable iff (!rst_n)
    (ready && mode_cap && tick_256 && $past(ready) && $past(tick_256)) |=> (!ready || !tick_256));

  p_mode_hold_r5: assert property (@(posedge mclk) disable iff (!rst_n)
    (ready && $past(ready)) |-> $stable(mode_cap));

  p_drop_on_silence_r6: assert property (@(posedge mclk) disable iff (!rst_n)
    $fell(ready) |-> !$past(frame_edge));

  p_strobe_width_r7: assert property (@(posedge mclk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  p_pdn_no_tick_r8: assert property (@(posedge mclk) disable iff (!rst_n)
    !ready |-> !tick_256);
endmodule

bind clk_mode_seq clk_mode_seq_checker u_chk (
  .mclk(mclk), .rst_n(rst_n), .tick_256(tick_256), .ready(ready),
  .frame_start(frame_start), .frame_edge(frame_edge), .mode_cap(mode_cap)
);

// File: tb/clk_mode_seq_bench.sv
module clk_mode_seq_bench;
  localparam int TMO = 1024;

  logic mclk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_384 = 1'b0;
  logic frame_clk = 1'b0;
  logic tick_256, ready, frame_start;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit fr_on = 0;
  int half = 8;
  int fcnt = 0;

  always #10 mclk = ~mclk;

  clk_mode_seq u_clk_mode_seq (
    .mclk(mclk), .rst_n(rst_n), .sel_384(sel_384), .frame_clk(frame_clk),
    .tick_256(tick_256), .ready(ready), .frame_start(frame_start)
  );

  // reference model, restated from the requirements
  bit f1, f2, f3;
  int m_st;      // 0 off, 1 one edge seen, 2 running
  int m_gap;
  bit m_sel;
  int m_cnt3;

  function automatic bit exp_tick(int st, bit sel, int c3);
    if (st != 2) return 0;
    return sel ? (c3 % 3 != 2) : 1;
  endfunction

  always @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      f1 <= 0; f2 <= 0; f3 <= 0; m_st <= 0; m_gap <= 0; m_sel <= 0; m_cnt3 <= 0;
    end else begin
      automatic bit ev = (f2 != f3);
      f1 <= frame_clk; f2 <= f1; f3 <= f2;
      if (m_st != 2) m_sel <= sel_384;
      m_cnt3 <= (m_st == 2) ? m_cnt3 + 1 : 0;
      if (m_st == 0) begin
        if (ev) m_st <= 1;
        m_gap <= 0;
      end else if (ev) begin
        m_st <= 2; m_gap <= 0;
        if (m_st != 2) m_cnt3 <= 0;
      end else if (m_gap + 1 >= TMO) begin
        m_st <= 0; m_gap <= 0;
      end else m_gap <= m_gap + 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge mclk) begin
    cyc++;
    if (rst_n) begin
      chk("R2/R6 ready", ready, m_st == 2);
      chk("R3/R4/R8 tick_256", tick_256, exp_tick(m_st, m_sel, m_cnt3));
      chk("R7 frame_start", frame_start, (m_st == 2) && f2 && !f3);
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // frame clock generator
  always @(negedge mclk) begin
    if (fr_on) begin
      if (fcnt >= half - 1) begin frame_clk <= ~frame_clk; fcnt <= 0; end
      else fcnt <= fcnt + 1;
    end else fcnt <= 0;
  end

  task automatic idle(int n);
    repeat (n) @(negedge mclk);
  endtask

  initial begin
    void'($urandom(32'h5eed_4c1));
    // R1: outputs quiet inside reset
    idle(3);
    chk("R1 ready", ready, 0);
    chk("R1 tick_256", tick_256, 0);
    chk("R1 frame_start", frame_start, 0);
    rst_n = 1'b1;

    // R2: no frame clock -> stays down
    idle(60);
    chk("R2 ready without frame clock", ready, 0);
    chk("R8 tick without ready", tick_256, 0);

    // R2 latency: two manual edges five cycles apart
    frame_clk = 1'b1; idle(5);
    frame_clk = 1'b0;
    idle(2);
    chk("R2 ready one edge early", ready, 0);
    idle(1);
    chk("R2 ready on latency edge", ready, 1);
    chk("R3 first tick full rate", tick_256, 1);

    // keep running in 256fs mode; flip select mid-run (R5)
    fr_on = 1; half = 6;
    idle(40);
    sel_384 = 1'b1;
    idle(30);
    chk("R5 select ignored while ready", tick_256, 1);

    // R6: frame clock silent longer than timeout
    fr_on = 0;
    idle(TMO + 10);
    chk("R6 dropped after silence", ready, 0);

    // single isolated edge, then silence: armed timeout (R6)
    frame_clk = ~frame_clk;
    idle(TMO + 10);
    chk("R6 armed timeout", ready, 0);

    // requalify in 384fs mode (R4)
    fr_on = 1; half = 12;
    idle(200);
    chk("R4 running in 384 mode", ready, 1);

    // random segments
    for (int seg = 0; seg < 12; seg++) begin
      half = 2 + ($urandom % 30);
      if ($urandom % 3 == 0) sel_384 = ~sel_384;
      if ($urandom % 4 == 0) begin fr_on = 0; idle(TMO + ($urandom % 40)); fr_on = 1; end
      idle(300 + ($urandom % 500));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule